// File: doc/BRIEF.md
# Base-Index-Displacement Address Generator

This block forms storage addresses for a machine with sixteen 32-bit general registers. A request carries the address part of an instruction: a 12-bit displacement, a 4-bit base register number and a 4-bit index register number. The block looks up the named registers in its own register file and adds the base contents, the index contents and the zero-extended displacement. It returns the low 24 bits of that sum as the effective address.

Register number 0 never supplies its contents to an address. In either field it stands for the value zero. A format select input marks instruction formats that have no index field. For those requests the index number is ignored and the index term is zero. A write port loads the register file. Forming an address never changes a register or the request's fields.

A request is taken in any cycle where `req_valid` is high. On the next clock edge the address is registered and `done` pulses for one cycle. The address output then holds its value until the next request.

Top module: `bxd_agen`

## Requirements
- R1: `ea` equals base register contents plus index register contents plus the zero-extended displacement, taken modulo 2^24. For example, index 6 holding 2048, base 7 holding 6024 and displacement 1012 give 9084.
- R2: A base field of 0 adds zero, whatever register 0 holds.
- R3: An index field of 0 adds zero, whatever register 0 holds.
- R4: When `no_index` is 1, the index field is ignored and the index term is zero. When `no_index` is 0, the index term is used.
- R5: A carry out of bit 23 of the sum is dropped silently. `ea` keeps only bits 23:0.
- R6: When `req_valid` is high at a clock edge, `done` is high for the cycle that follows that edge. `done` is low after any edge where `req_valid` was low.
- R7: `ea` keeps its last value in every cycle after an edge with no request.
- R8: A register write takes effect at the clock edge. A request in the same cycle as a write to the register it names uses the old contents.
- R9: After reset, `done` is 0, `ea` is 0 and every register holds 0.
- R10: Forming an address leaves the register contents unchanged. Repeating a request with the same fields gives the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| no_index | input | 1 | 1 = format without an index field |
| idx_sel | input | 4 | Index register number |
| base_sel | input | 4 | Base register number |
| disp | input | 12 | Unsigned displacement |
| wr_en | input | 1 | Register file write enable |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 32 | Register write data |
| done | output | 1 | One-cycle pulse: `ea` is new |
| ea | output | 24 | Effective address |

## Verification
Each address is due exactly one clock edge after the edge that takes its request, and `done` marks that same cycle. The driver changes inputs on the falling edge and pushes the expected address into a queue when it raises `req_valid`. The monitor samples on the next falling edge and pops one entry for each `done` it sees. A `done` with no queued entry counts as a failure. Idle falling edges are used to confirm that `done` stays low and that `ea` holds. The expected addresses come from a register model kept in the bench. That model is updated only after the expected value of a request issued in the same cycle as a write has been computed.

// File: rtl/agen_pkg.sv
package agen_pkg;

   // Adder structure choices for the three-term sum.
   typedef enum int {
      ADD_RIPPLE = 0,
      ADD_CSA    = 1
   } add_style_e;

   // Zero-extend a displacement field to the address width.
   function automatic logic [63:0] zext64(input logic [63:0] v);
      return v;
   endfunction

endpackage

// File: rtl/agen_regfile.sv
module agen_regfile #(
   parameter int DATA_W = 32,
   parameter int NREGS  = 16,
   parameter int SEL_W  = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [SEL_W-1:0]  rd_sel_b,
   output logic [DATA_W-1:0] rd_data_b
);

   logic [DATA_W-1:0] regs [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (wr_en && (wr_sel == SEL_W'(g)))
            regs[g] <= wr_data;
      end
   end

   // Reads are combinational from the stored state, so a read in the
   // same cycle as a write sees the value before the edge.
   assign rd_data_a = regs[rd_sel_a];
   assign rd_data_b = regs[rd_sel_b];

endmodule

// File: rtl/agen_term_sel.sv
module agen_term_sel #(
   parameter int DATA_W     = 32,
   parameter int SEL_W      = 4,
   parameter int TERM_W     = 24,
   parameter bit REG0_IS_NULL = 1'b1
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic              use_term,
   input  logic [DATA_W-1:0] reg_data,
   output logic [TERM_W-1:0] term
);

   logic active;

   if (REG0_IS_NULL) begin : g_null0
      assign active = use_term && (sel != '0);
   end else begin : g_plain
      assign active = use_term;
   end

   assign term = active ? reg_data[TERM_W-1:0] : '0;

endmodule

// File: rtl/agen_adder3.sv
module agen_adder3
   import agen_pkg::*;
#(
   parameter int         SUM_W  = 24,
   parameter int         DISP_W = 12,
   parameter add_style_e STYLE  = ADD_CSA
) (
   input  logic [SUM_W-1:0]  term_a,
   input  logic [SUM_W-1:0]  term_b,
   input  logic [DISP_W-1:0] disp,
   output logic [SUM_W-1:0]  sum
);

   logic [SUM_W-1:0] dext;
   assign dext = {{(SUM_W-DISP_W){1'b0}}, disp};

   if (STYLE == ADD_CSA) begin : g_csa
      logic [SUM_W-1:0] s_vec;
      logic [SUM_W-1:0] c_vec;
      for (genvar i = 0; i < SUM_W; i++) begin : g_bit
         assign s_vec[i] = term_a[i] ^ term_b[i] ^ dext[i];
         if (i == 0) begin : g_c0
            assign c_vec[0] = 1'b0;
         end else begin : g_cn
            assign c_vec[i] = (term_a[i-1] & term_b[i-1]) |
                              (term_a[i-1] & dext[i-1])   |
                              (term_b[i-1] & dext[i-1]);
         end
      end
      assign sum = s_vec + c_vec;
   end else begin : g_ripple
      assign sum = term_a + term_b + dext;
   end

endmodule

// File: rtl/bxd_agen.sv
module bxd_agen
   import agen_pkg::*;
#(
   parameter int         DATA_W       = 32,
   parameter int         ADDR_W       = 24,
   parameter int         NREGS        = 16,
   parameter int         DISP_W       = 12,
   parameter bit         REG0_IS_NULL = 1'b1,
   parameter add_style_e ADD_STYLE    = ADD_CSA,
   localparam int        SEL_W        = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              no_index,
   input  logic [SEL_W-1:0]  idx_sel,
   input  logic [SEL_W-1:0]  base_sel,
   input  logic [DISP_W-1:0] disp,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              done,
   output logic [ADDR_W-1:0] ea
);

   if (ADDR_W > DATA_W) begin : g_chk_aw
      $error("ADDR_W must not exceed DATA_W");
   end
   if (DISP_W > ADDR_W) begin : g_chk_dw
      $error("DISP_W must not exceed ADDR_W");
   end
   if ((1 << SEL_W) != NREGS) begin : g_chk_nr
      $error("NREGS must be a power of two");
   end

   logic [DATA_W-1:0] base_data, idx_data;
   logic [ADDR_W-1:0] base_term, idx_term, sum_d;

   agen_regfile #(.DATA_W(DATA_W), .NREGS(NREGS), .SEL_W(SEL_W)) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .rd_sel_a  (base_sel),
      .rd_data_a (base_data),
      .rd_sel_b  (idx_sel),
      .rd_data_b (idx_data)
   );

   agen_term_sel #(.DATA_W(DATA_W), .SEL_W(SEL_W), .TERM_W(ADDR_W),
                   .REG0_IS_NULL(REG0_IS_NULL)) u_base_term (
      .sel      (base_sel),
      .use_term (1'b1),
      .reg_data (base_data),
      .term     (base_term)
   );

   agen_term_sel #(.DATA_W(DATA_W), .SEL_W(SEL_W), .TERM_W(ADDR_W),
                   .REG0_IS_NULL(REG0_IS_NULL)) u_idx_term (
      .sel      (idx_sel),
      .use_term (!no_index),
      .reg_data (idx_data),
      .term     (idx_term)
   );

   agen_adder3 #(.SUM_W(ADDR_W), .DISP_W(DISP_W), .STYLE(ADD_STYLE)) u_add (
      .term_a (base_term),
      .term_b (idx_term),
      .disp   (disp),
      .sum    (sum_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
         ea   <= '0;
      end else begin
         done <= req_valid;
         if (req_valid)
            ea <= sum_d;
      end
   end

endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
   parameter int ADDR_W = 24,
   parameter int DISP_W = 12,
   parameter int SEL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              no_index,
   input logic [SEL_W-1:0]  idx_sel,
   input logic [SEL_W-1:0]  base_sel,
   input logic [DISP_W-1:0] disp,
   input logic              done,
   input logic [ADDR_W-1:0] ea
);

   // R6: a taken request yields done in the following cycle
   a_r6_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> done);

   // R6: no done without a request
   a_r6_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !done);

   // R7: address holds when nothing is requested
   a_r7_ea_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(ea));

   // R2: base 0 with no index term leaves only the displacement
   a_r2_base_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && base_sel == '0 && no_index) |=>
         (ea == ADDR_W'($past(disp))));

   // R3: index field 0 adds nothing
   a_r3_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !no_index && idx_sel == '0 && base_sel == '0) |=>
         (ea == ADDR_W'($past(disp))));

   // R4: no_index ignores whatever the index field names
   a_r4_no_index: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && no_index && base_sel == '0 && idx_sel != '0) |=>
         (ea == ADDR_W'($past(disp))));

endmodule

bind bxd_agen agen_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SEL_W(SEL_W)) u_agen_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .no_index  (no_index),
   .idx_sel   (idx_sel),
   .base_sel  (base_sel),
   .disp      (disp),
   .done      (done),
   .ea        (ea)
);

// File: tb/test_bxd_agen.sv
module test_bxd_agen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        no_index = 1'b0;
   logic [3:0]  idx_sel = '0;
   logic [3:0]  base_sel = '0;
   logic [11:0] disp = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        done;
   logic [23:0] ea;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [23:0] exp;
      string       tag;
   } item_t;

   item_t       sb[$];
   logic [31:0] model [16];
   logic [23:0] last_ea = '0;

   always #5 clk = ~clk;

   bxd_agen i_bxd_agen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .no_index(no_index),
      .idx_sel(idx_sel), .base_sel(base_sel), .disp(disp), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .done(done), .ea(ea)
   );

   function automatic logic [23:0] expect_ea(input logic [3:0] x, input logic [3:0] b,
                                             input logic [11:0] d, input logic ni);
      logic [31:0] s;
      s = {20'd0, d};
      if (b != 0) s = s + model[b];
      if (!ni && x != 0) s = s + model[x];
      return s[23:0];
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Monitor: pops one expected item per done pulse
   always @(negedge clk) begin
      if (rst_n && !finished && done) begin
         if (sb.size() == 0) begin
            check(1'b0, "R6 done without request", 32'(done), 32'd0);
         end else begin
            item_t it;
            it = sb.pop_front();
            check(ea == it.exp, it.tag, 32'(ea), 32'(it.exp));
            last_ea = it.exp;
         end
      end
   end

   task automatic write_reg(input logic [3:0] r, input logic [31:0] v);
      @(negedge clk);
      req_valid = 1'b0;
      wr_en = 1'b1; wr_sel = r; wr_data = v;
      model[r] = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic request(input logic [3:0] x, input logic [3:0] b,
                          input logic [11:0] d, input logic ni, input string tag);
      item_t it;
      @(negedge clk);
      wr_en = 1'b0;
      req_valid = 1'b1; idx_sel = x; base_sel = b; disp = d; no_index = ni;
      it.exp = expect_ea(x, b, d, ni);
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle_check(input string tag);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check(done == 1'b0, {"R6 ", tag}, 32'(done), 32'd0);
      check(ea == last_ea, {"R7 ", tag}, 32'(ea), 32'(last_ea));
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R9 reset done", 32'(done), 32'd0);
      check(ea == 24'd0, "R9 reset ea", 32'(ea), 32'd0);
      rst_n = 1'b1;
      // R9: registers are zero after reset
      request(4'd5, 4'd9, 12'd0, 1'b0, "R9 regs zero");
      idle_check("after reset read");

      // R1: worked example
      write_reg(4'd6, 32'd2048);
      write_reg(4'd7, 32'd6024);
      request(4'd6, 4'd7, 12'd1012, 1'b0, "R1 example 9084");
      idle_check("after example");
      // R10: repeat yields the same address
      request(4'd6, 4'd7, 12'd1012, 1'b0, "R10 repeat");
      idle_check("after repeat");

      // R2 / R3: register 0 holds nonzero but contributes zero
      write_reg(4'd0, 32'h0012_3456);
      request(4'd6, 4'd0, 12'd7, 1'b0, "R2 base zero");
      request(4'd0, 4'd7, 12'd9, 1'b0, "R3 index zero");
      request(4'd0, 4'd0, 12'hFFF, 1'b0, "R2 R3 both zero");
      idle_check("after zero regs");

      // R4: no_index ignores the index field
      request(4'd6, 4'd7, 12'd1012, 1'b1, "R4 no index");
      request(4'd6, 4'd0, 12'd33, 1'b1, "R4 no index base0");
      idle_check("after no index");

      // R5: carry out of bit 23 dropped
      write_reg(4'd3, 32'hFFFF_F000);
      write_reg(4'd4, 32'h0000_2000);
      request(4'd4, 4'd3, 12'hABC, 1'b0, "R5 wrap");
      write_reg(4'd8, 32'hFFFF_FFFF);
      request(4'd8, 4'd8, 12'hFFF, 1'b0, "R5 max terms");
      idle_check("after wrap");

      // R8: same-cycle write and read returns old value
      begin
         item_t it;
         @(negedge clk);
         req_valid = 1'b1; idx_sel = 4'd0; base_sel = 4'd7; disp = 12'd1;
         no_index = 1'b0;
         wr_en = 1'b1; wr_sel = 4'd7; wr_data = 32'd500000;
         it.exp = expect_ea(4'd0, 4'd7, 12'd1, 1'b0);
         it.tag = "R8 old value on same-cycle write";
         sb.push_back(it);
         model[7] = 32'd500000;
      end
      request(4'd0, 4'd7, 12'd1, 1'b0, "R8 new value after edge");
      idle_check("after write race");

      // Mixed patterns with random writes
      for (int k = 0; k < 40; k++) begin
         if (k % 4 == 0) write_reg(4'($urandom), $urandom);
         request(4'($urandom), 4'($urandom), 12'($urandom), 1'($urandom),
                 "R1 R4 mixed");
      end
      idle_check("end");
      check(sb.size() == 0, "R6 all results seen", 32'(sb.size()), 32'd0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule